// File: doc/BRIEF.md
# Interrupt Pin Swizzle Router

This block turns assert and release events from PCI functions into level signals on sixteen legacy interrupt request lines. Every event names a source slot, and carries the function's interrupt pin byte and its device/function key. The device number sits in key bits 7:3. The block rotates the 1-based pin by the device number onto one of four shared lines. It then reads the target IRQ number from one of four programmable routing bytes. These bytes belong to the bridge's configuration space at offsets 0x60 to 0x63.

Each source slot is a two-state machine. SRC_IDLE means the source holds no interrupt. SRC_ACTIVE means it holds one, and the shared line it was given is stored. The ASSERT transition (SRC_IDLE to SRC_ACTIVE) fires on a valid raise event that has a legal pin, and it stores the computed shared line. The RELEASE transition (SRC_ACTIVE to SRC_IDLE) fires on a valid lower event. Every other input leaves the state where it is.

Each IRQ output is the OR of all active sources whose stored line routes to it. A line that several devices share therefore stays high until the last of them releases it.

Top module: `irq_swizzle_router`

## Requirements
- R1: After reset, all sixteen IRQ outputs are low, every source is in SRC_IDLE, and every routing byte holds 0x80, which is disabled.
- R2: The shared line index is ((pin - 1) + (dev - 1)) mod 4. Here pin is the evt_pin byte (A=1 to D=4) and dev is evt_key[7:3]. A device number of 0 therefore wraps to an offset of 3.
- R3: A write with rt_we high stores rt_data into the routing byte of shared line rt_sel (0 to 3, matching configuration offsets 0x60 to 0x63). A route whose byte holds value n below 16 drives IRQ n for that line.
- R4: A routing byte with bit 7 set, or with a value above 15, disables its route. No IRQ output is driven for that shared line.
- R5: A raise event with a pin byte of 0 or above 4 is ignored, and the source stays in SRC_IDLE.
- R6: A lower event releases an active source. A lower event on an idle source has no effect.
- R7: An IRQ output stays high for as long as any active source routes to it.
- R8: A change to a routing byte applies, in the next cycle, to every source that is already active.
- R9: A raise or lower event sampled at a clock edge changes the IRQ outputs right after that edge, so the change is visible one cycle later.
- R10: A raise event on a source that is already active keeps the shared line stored at its ASSERT. The new pin and key values are ignored.
- R11: When two shared lines route to the same IRQ number, that output is the OR of both.
- R12: With evt_valid low, the evt_raise, evt_src, evt_pin and evt_key inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is present this cycle |
| evt_raise | input | 1 | 1 = assert interrupt, 0 = release interrupt |
| evt_src | input | SRC_W | Source slot of the event |
| evt_pin | input | 8 | Interrupt pin byte of the function (1 to 4 are legal) |
| evt_key | input | 8 | Device/function key; bits 7:3 are the device number |
| rt_we | input | 1 | Routing byte write strobe |
| rt_sel | input | 2 | Shared line whose routing byte is written |
| rt_data | input | 8 | New routing byte |
| irq_lvl | output | IRQ_N | Level outputs, one per IRQ number |

## Verification
Each state change, whether from an event or from a routing write, lands at the clock edge where the input is sampled. The IRQ outputs are decoded without registers from that state, so every result is due exactly one clock after its stimulus. The driver applies each stimulus at a falling edge and waits for the rising edge. Only then does it update its own model and queue the expected IRQ vector. The monitor takes that vector off the queue at the next falling edge, half a cycle after the output settled and before the next input change.

// File: rtl/irq_swz_pkg.sv
package irq_swz_pkg;

    // number of shared lines the pin is rotated across
    localparam int LINE_N = 4;
    localparam int LINE_W = $clog2(LINE_N);

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {
        SRC_IDLE   = 1'b0,
        SRC_ACTIVE = 1'b1
    } src_state_t;

    // reset value of a routing byte: route disabled
    localparam logic [7:0] ROUTE_OFF = 8'h80;

endpackage

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_swz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       raise,
    input  logic [7:0] pin,
    input  logic [7:0] key,
    output logic       active_o,
    output line_t      line_o
);

    src_state_t st_q, st_d;
    line_t      line_q, line_d;

    logic [4:0] dev;
    logic [7:0] rot_sum;
    line_t      calc_line;
    logic       pin_valid;
    logic       unused_key_bits;

    // (pin-1)+(dev-1) mod 4 equals pin+dev+2 mod 4
    assign dev       = key[7:3];
    assign rot_sum   = pin + {3'b000, dev} + 8'd2;
    assign calc_line = rot_sum[LINE_W-1:0];
    assign pin_valid = (pin != 8'd0) && (pin <= 8'd4);
    assign unused_key_bits = ^{rot_sum[7:LINE_W], key[2:0]};

    // next-state logic: ASSERT and RELEASE transitions
    always_comb begin
        st_d   = st_q;
        line_d = line_q;
        unique case (st_q)
            SRC_IDLE: begin
                if (hit && raise && pin_valid) begin
                    st_d   = SRC_ACTIVE;
                    line_d = calc_line;
                end
            end
            SRC_ACTIVE: begin
                if (hit && !raise) begin
                    st_d = SRC_IDLE;
                end
            end
            default: st_d = SRC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SRC_IDLE;
            line_q <= '0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
        end
    end

    // outputs
    always_comb begin
        line_o = line_q;
        unique case (st_q)
            SRC_IDLE:   active_o = 1'b0;
            SRC_ACTIVE: active_o = 1'b1;
            default:    active_o = 1'b0;
        endcase
    end

    // R5
    bad_pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_IDLE && hit && raise && !pin_valid) |=> (st_q == SRC_IDLE));

    // R6
    lower_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_ACTIVE && hit && !raise) |=> (st_q == SRC_IDLE));

    // R10
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_ACTIVE) |=> (st_q == SRC_IDLE || $stable(line_q)));

    // R12
    no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |=> $stable(st_q));

endmodule

// File: rtl/irq_route_tbl.sv
module irq_route_tbl
    import irq_swz_pkg::*;
#(
    parameter int IRQ_N = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  line_t                             sel,
    input  logic [7:0]                        data,
    output logic [LINE_N-1:0][IRQ_N-1:0]      mask_o
);

    localparam int IDX_W = $clog2(IRQ_N);

    generate
        for (genvar g = 0; g < LINE_N; g++) begin : g_line
            logic [7:0] rt_q;
            logic       en;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rt_q <= ROUTE_OFF;
                end else if (we && sel == line_t'(g)) begin
                    rt_q <= data;
                end
            end

            assign en = !rt_q[7] && (int'(rt_q) < IRQ_N);

            always_comb begin
                mask_o[g] = '0;
                if (en) begin
                    mask_o[g][rt_q[IDX_W-1:0]] = 1'b1;
                end
            end

            // R3
            write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && sel == line_t'(g)) |=> (rt_q == $past(data)));

            // R4
            disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rt_q[7] || int'(rt_q) >= IRQ_N) |-> (mask_o[g] == '0));

            // R3
            mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(mask_o[g]));
        end
    endgenerate

endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge
    import irq_swz_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IRQ_N   = 16
) (
    input  logic [NUM_SRC-1:0]               active,
    input  logic [NUM_SRC-1:0][LINE_W-1:0]   line,
    input  logic [LINE_N-1:0][IRQ_N-1:0]     mask,
    output logic [IRQ_N-1:0]                 irq_o
);

    always_comb begin
        irq_o = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (active[s]) begin
                irq_o = irq_o | mask[line[s]];
            end
        end
    end

endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
    import irq_swz_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IRQ_N   = 16,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             evt_raise,
    input  logic [SRC_W-1:0] evt_src,
    input  logic [7:0]       evt_pin,
    input  logic [7:0]       evt_key,
    input  logic             rt_we,
    input  logic [1:0]       rt_sel,
    input  logic [7:0]       rt_data,
    output logic [IRQ_N-1:0] irq_lvl
);

    logic [NUM_SRC-1:0]             src_act;
    logic [NUM_SRC-1:0][LINE_W-1:0] src_line;
    logic [LINE_N-1:0][IRQ_N-1:0]   route_mask;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            logic hit;
            line_t ln;
            assign hit = evt_valid && (evt_src == SRC_W'(g));

            irq_src_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .hit      (hit),
                .raise    (evt_raise),
                .pin      (evt_pin),
                .key      (evt_key),
                .active_o (src_act[g]),
                .line_o   (ln)
            );
            assign src_line[g] = ln;
        end
    endgenerate

    irq_route_tbl #(.IRQ_N(IRQ_N)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rt_we),
        .sel    (line_t'(rt_sel)),
        .data   (rt_data),
        .mask_o (route_mask)
    );

    irq_level_merge #(.NUM_SRC(NUM_SRC), .IRQ_N(IRQ_N)) u_merge (
        .active (src_act),
        .line   (src_line),
        .mask   (route_mask),
        .irq_o  (irq_lvl)
    );

    // R1 R7
    no_source_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_act == '0) |-> (irq_lvl == '0));

    // R9
    raise_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_raise && evt_pin >= 8'd1 && evt_pin <= 8'd4)
        |=> src_act[$past(evt_src)]);

endmodule

// File: tb/irq_swizzle_router_tb_top.sv
`timescale 1ns/1ps
module irq_swizzle_router_tb_top;

    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic       evt_raise = 1'b0;
    logic [2:0] evt_src = '0;
    logic [7:0] evt_pin = '0;
    logic [7:0] evt_key = '0;
    logic       rt_we = 1'b0;
    logic [1:0] rt_sel = '0;
    logic [7:0] rt_data = '0;
    logic [15:0] irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    logic       m_act[NS];
    int         m_line[NS];
    logic [7:0] m_rt[4];

    always #2 clk = ~clk;

    irq_swizzle_router #(.NUM_SRC(NS), .IRQ_N(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_raise(evt_raise), .evt_src(evt_src),
        .evt_pin(evt_pin), .evt_key(evt_key),
        .rt_we(rt_we), .rt_sel(rt_sel), .rt_data(rt_data),
        .irq_lvl(irq_lvl)
    );

    function automatic logic [15:0] model_irq();
        logic [15:0] r = '0;
        for (int s = 0; s < NS; s++) begin
            if (m_act[s] && m_rt[m_line[s]] < 8'd16) r[m_rt[m_line[s]][3:0]] = 1'b1;
        end
        return r;
    endfunction

    // monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (irq_lvl !== e) begin
                errors++;
                $display("FAIL %s: irq_lvl actual=%h expected=%h", t, irq_lvl, e);
            end
        end
    end

    task automatic op(input logic v, input logic rs, input int src,
                      input logic [7:0] pin, input logic [7:0] key,
                      input logic we, input logic [1:0] sel, input logic [7:0] data,
                      input string tag);
        @(negedge clk);
        evt_valid = v; evt_raise = rs; evt_src = 3'(src);
        evt_pin = pin; evt_key = key;
        rt_we = we; rt_sel = sel; rt_data = data;
        @(posedge clk);
        #1;
        if (v) begin
            if (rs) begin
                if (!m_act[src] && pin >= 8'd1 && pin <= 8'd4) begin
                    m_act[src]  = 1'b1;
                    m_line[src] = ((int'(pin) - 1) + (int'(key[7:3]) - 1) + 8) % 4;
                end
            end else begin
                m_act[src] = 1'b0;
            end
        end
        if (we) m_rt[sel] = data;
        exp_q.push_back(model_irq());
        tag_q.push_back(tag);
        evt_valid = 1'b0; rt_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin m_act[s] = 1'b0; m_line[s] = 0; end
        for (int i = 0; i < 4; i++) m_rt[i] = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        exp_q.push_back(16'h0000); tag_q.push_back("R1");
        // R1: routes disabled after reset, a legal raise drives nothing
        op(1, 1, 7, 8'd1, 8'h08, 0, 2'd0, 8'h00, "R1");
        op(1, 0, 7, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R1");
        // R3: program routes
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd0, 8'd5,  "R3");
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd1, 8'd9,  "R3");
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd3, 8'd11, "R3");
        // R2 R9: pin A dev1 -> line0 -> IRQ5
        op(1, 1, 0, 8'd1, 8'h08, 0, 2'd0, 8'h00, "R2");
        // R2: pin B dev1 fn3 -> line1 -> IRQ9
        op(1, 1, 1, 8'd2, 8'h0B, 0, 2'd0, 8'h00, "R2");
        // R2: pin A dev0 wraps -> line3 -> IRQ11
        op(1, 1, 2, 8'd1, 8'h00, 0, 2'd0, 8'h00, "R2");
        // R2 R7: pin D dev2 -> line0 -> IRQ5 shared
        op(1, 1, 3, 8'd4, 8'h10, 0, 2'd0, 8'h00, "R2");
        // R7: lower src0, IRQ5 still held by src3
        op(1, 0, 0, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R7");
        // R6: lower an idle source, no change
        op(1, 0, 0, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R6");
        // R5: illegal pins ignored
        op(1, 1, 4, 8'd0, 8'h08, 0, 2'd0, 8'h00, "R5");
        op(1, 1, 4, 8'd5, 8'h08, 0, 2'd0, 8'h00, "R5");
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd0, 8'd6,  "R5");
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd0, 8'd5,  "R5");
        // R4: src5 pin C dev1 -> line2, still disabled
        op(1, 1, 5, 8'd3, 8'h08, 0, 2'd0, 8'h00, "R4");
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd2, 8'h10, "R4");
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd2, 8'h83, "R4");
        // R8: enable route for line2 while src5 active
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd2, 8'd3,  "R8");
        // R10: re-raise src3 with other pin and key, line kept
        op(1, 1, 3, 8'd2, 8'h18, 0, 2'd0, 8'h00, "R10");
        // R11 R8: line0 moves onto IRQ9, shared with line1
        op(0, 0, 0, 8'd0, 8'h00, 1, 2'd0, 8'd9,  "R11");
        op(1, 0, 1, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R11");
        // R12: invalid event fields ignored
        op(0, 0, 3, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R12");
        op(0, 1, 6, 8'd1, 8'h08, 0, 2'd0, 8'h00, "R12");
        // R9 R8: event and route write in the same cycle
        op(1, 1, 6, 8'd2, 8'h10, 1, 2'd1, 8'd15, "R9");
        // R6: release everything
        op(1, 0, 3, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R6");
        op(1, 0, 2, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R6");
        op(1, 0, 5, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R6");
        op(1, 0, 6, 8'd0, 8'h00, 0, 2'd0, 8'h00, "R6");
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule